// File: doc/BRIEF.md
# Parallel Peripheral Port with Control Register

This block is one half of a parallel interface adapter: eight general-purpose pins whose directions are set bit by bit, one interrupt input line, one programmable active-low output line, and an interrupt request output. A CPU reaches it through two register addresses. The shared address (select 0) reaches either the port data register or the direction register, depending on one control bit. The other address (select 1) reaches the control register. A second port is built by instantiating the block a second time.

Pin inputs and the interrupt line pass through two-flop synchronisers. The interrupt line is watched for falling edges. A falling edge sets a sticky status flag. A read of the port data register clears the flag. The interrupt request output is the flag gated by an enable bit. The asynchronous reset input is released through a two-flop reset synchroniser, so the block leaves reset on the second rising clock edge after `rst_n` goes high.

Top module: `pport_side`

## Requirements
- R1: After reset the data and direction registers read 0x00, all `pin_oe` bits are 0, the control register reads 0x08, `ctl_line_n` is 1 and `irq` is 0.
- R2: At select 0, control bit 2 chooses the register: 1 reaches the data register and 0 reaches the direction register, for both writes and reads. At select 1 the control register is reached.
- R3: `pin_oe[i]` equals direction bit i, and `pin_out` always presents the data register value.
- R4: A data-register read returns the data register bit where the direction bit is 1. Where the direction bit is 0, it returns the pin value as sampled two rising edges earlier.
- R5: A control write stores bits 6..0. Bits 1, 4, 5 and 6 read back as written and have no other effect. Read bit 7 is the status flag, and writes to bit 7 are ignored.
- R6: If `int_line` is sampled high and then low on consecutive rising edges k-1 and k, the status flag reads 1 after rising edge k+2.
- R7: A read at select 0 with control bit 2 equal to 1 clears the flag at that clock edge, unless a new falling edge is detected in the same cycle; in that case the flag stays 1. Direction-register reads and control reads leave the flag unchanged.
- R8: `irq` is 1 exactly when the status flag is 1 and control bit 0 is 1.
- R9: `ctl_line_n` follows control bit 3. Writing 0 drives the line low, which turns the attached device on.
- R10: Rising edges and steady levels on `int_line` never set the status flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 1 | 0: shared data/direction address, 1: control register |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe (side effect only; read data is combinational) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the selected register |
| pin_in | input | 8 | Pin input levels |
| pin_out | output | 8 | Pin output levels (data register) |
| pin_oe | output | 8 | Per-pin output enable |
| int_line | input | 1 | Peripheral interrupt line; falling edge sensitive |
| ctl_line_n | output | 1 | Programmable active-low output line |
| irq | output | 1 | Interrupt request, active high |

## Verification
The mixed-direction read is tried with several direction masks and pin patterns, so that a swapped or inverted mask term is exposed. Interrupt falling edges are presented alone, together with a clearing read in the same cycle, and with only a direction read or a control read. These cases separate clear priority from set priority and show whether the clear is tied to the correct address. Rising edges and an enable toggle while the flag is pending separate edge detection from level detection and show that the request is gated.

// File: rtl/pport_pkg.sv
package pport_pkg;
  localparam int CTL_W      = 8;
  localparam int B_IRQ_EN   = 0;
  localparam int B_DATA_SEL = 2;
  localparam int B_LINE     = 3;
  localparam int B_FLAG     = 7;
  localparam logic [CTL_W-1:0] CTL_RESET = 8'h08;
endpackage

// File: rtl/pport_rst_sync.sv
module pport_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic r1_q, r2_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r1_q <= 1'b0;
      r2_q <= 1'b0;
    end else begin
      r1_q <= 1'b1;
      r2_q <= r1_q;
    end
  end
  assign rst_n_sync = r2_q;
endmodule

// File: rtl/pport_sync.sv
module pport_sync #(
  parameter int          W       = 8,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg_q [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      logic [W-1:0] src;
      if (g == 0) begin : g_first
        assign src = d;
      end else begin : g_rest
        assign src = stg_q[g-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[g] <= RST_VAL;
        else        stg_q[g] <= src;
      end
    end
  endgenerate

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/pport_io.sv
module pport_io #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_shared,
  input  logic         data_sel,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] pin_sync,
  output logic [W-1:0] pin_out,
  output logic [W-1:0] pin_oe,
  output logic [W-1:0] shared_rdata
);
  logic [W-1:0] data_q, data_d;
  logic [W-1:0] dir_q, dir_d;
  logic         data_en, dir_en;
  logic [W-1:0] port_view;

  always_comb begin
    data_en = wr_shared &  data_sel;
    dir_en  = wr_shared & ~data_sel;
    data_d  = data_en ? wdata : data_q;
    dir_d   = dir_en  ? wdata : dir_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      dir_q  <= '0;
    end else begin
      data_q <= data_d;
      dir_q  <= dir_d;
    end
  end

  genvar b;
  generate
    for (b = 0; b < W; b++) begin : g_bit
      assign port_view[b] = dir_q[b] ? data_q[b] : pin_sync[b];
    end
  endgenerate

  assign shared_rdata = data_sel ? port_view : dir_q;
  assign pin_out      = data_q;
  assign pin_oe       = dir_q;

  p_dir_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_shared && !data_sel) |=> (pin_oe == $past(wdata)));
  p_data_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_shared && data_sel) |=> (pin_out == $past(wdata)) && $stable(pin_oe));
  p_data_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_shared) |=> $stable(pin_out) && $stable(pin_oe));
endmodule

// File: rtl/pport_ctl.sv
module pport_ctl
  import pport_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_ctl,
  input  logic [CTL_W-1:0] wdata,
  input  logic             clr_req,
  input  logic             fall_evt,
  output logic [CTL_W-1:0] ctl_view,
  output logic             data_sel,
  output logic             line_n,
  output logic             irq
);
  logic [CTL_W-2:0] cfg_q, cfg_d;
  logic             flag_q, flag_d;

  always_comb begin
    cfg_d  = wr_ctl ? wdata[CTL_W-2:0] : cfg_q;
    flag_d = fall_evt | (flag_q & ~clr_req);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= CTL_RESET[CTL_W-2:0];
      flag_q <= 1'b0;
    end else begin
      cfg_q  <= cfg_d;
      flag_q <= flag_d;
    end
  end

  assign ctl_view = {flag_q, cfg_q};
  assign data_sel = cfg_q[B_DATA_SEL];
  assign line_n   = cfg_q[B_LINE];
  assign irq      = flag_q & cfg_q[B_IRQ_EN];

  p_flag_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fall_evt |=> ctl_view[B_FLAG]);
  p_flag_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && !fall_evt) |=> !ctl_view[B_FLAG]);
  p_flag_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_view[B_FLAG] && !clr_req) |=> ctl_view[B_FLAG]);
  p_no_spurious_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_view[B_FLAG] && !fall_evt) |=> !ctl_view[B_FLAG]);
  p_line_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctl |=> (line_n == $past(wdata[B_LINE])));
  p_cfg_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_ctl) |=> $stable(ctl_view[CTL_W-2:0]));
endmodule

// File: rtl/pport_side.sv
module pport_side
  import pport_pkg::*;
#(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         reg_sel,
  input  logic         wr_en,
  input  logic         rd_en,
  input  logic [7:0]   wdata,
  output logic [7:0]   rdata,
  input  logic [W-1:0] pin_in,
  output logic [W-1:0] pin_out,
  output logic [W-1:0] pin_oe,
  input  logic         int_line,
  output logic         ctl_line_n,
  output logic         irq
);
  logic             rst_n_i;
  logic [W-1:0]     pin_sync;
  logic             int_sync, int_prev_q;
  logic             fall_evt;
  logic             data_sel;
  logic             wr_shared, wr_ctl, clr_req;
  logic [W-1:0]     shared_rdata;
  logic [CTL_W-1:0] ctl_view;

  pport_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_i));

  pport_sync #(.W(W), .STAGES(STAGES), .RST_VAL('0)) u_pin_sync (
    .clk(clk), .rst_n(rst_n_i), .d(pin_in), .q(pin_sync));

  pport_sync #(.W(1), .STAGES(STAGES), .RST_VAL(1'b1)) u_int_sync (
    .clk(clk), .rst_n(rst_n_i), .d(int_line), .q(int_sync));

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) int_prev_q <= 1'b1;
    else          int_prev_q <= int_sync;
  end

  always_comb begin
    fall_evt  = int_prev_q & ~int_sync;
    wr_shared = wr_en & ~reg_sel;
    wr_ctl    = wr_en &  reg_sel;
    clr_req   = rd_en & ~reg_sel & data_sel;
  end

  pport_io #(.W(W)) u_io (
    .clk(clk), .rst_n(rst_n_i), .wr_shared(wr_shared), .data_sel(data_sel),
    .wdata(wdata[W-1:0]), .pin_sync(pin_sync), .pin_out(pin_out),
    .pin_oe(pin_oe), .shared_rdata(shared_rdata));

  pport_ctl u_ctl (
    .clk(clk), .rst_n(rst_n_i), .wr_ctl(wr_ctl), .wdata(wdata),
    .clr_req(clr_req), .fall_evt(fall_evt), .ctl_view(ctl_view),
    .data_sel(data_sel), .line_n(ctl_line_n), .irq(irq));

  always_comb begin
    rdata = '0;
    if (reg_sel) rdata = ctl_view;
    else         rdata[W-1:0] = shared_rdata;
  end

  p_irq_follows_r8: assert property (@(posedge clk) disable iff (!rst_n_i)
    (irq && !clr_req && !wr_ctl) |=> irq);
  p_irq_fall_r6: assert property (@(posedge clk) disable iff (!rst_n_i)
    (fall_evt && ctl_view[B_IRQ_EN] && !wr_ctl) |=> irq);
endmodule

// File: tb/sim_pport_side.sv
module sim_pport_side;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_sel = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic [7:0] pin_in = 8'h00;
  logic [7:0] pin_out, pin_oe;
  logic       int_line = 1'b1;
  logic       ctl_line_n, irq;

  int checks = 0;
  int fails  = 0;
  bit cmp_on = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pport_side u0 (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .pin_in(pin_in), .pin_out(pin_out),
    .pin_oe(pin_oe), .int_line(int_line), .ctl_line_n(ctl_line_n), .irq(irq));

  // Behavioural reference model
  logic [7:0] m_data = 0, m_dir = 0, m_cfg = 8'h08;
  bit         m_flag = 0;
  bit         m_r1 = 0, m_r2 = 0;
  logic [7:0] pin_hist[$] = '{8'h00, 8'h00};
  bit         int_hist[$] = '{1'b1, 1'b1, 1'b1};

  task automatic model_reset();
    m_data = 0; m_dir = 0; m_cfg = 8'h08; m_flag = 0;
    pin_hist = '{8'h00, 8'h00};
    int_hist = '{1'b1, 1'b1, 1'b1};
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_r1 = 0; m_r2 = 0; model_reset();
    end else begin
      if (!m_r2) model_reset();
      else begin
        bit fell, clr;
        fell = int_hist[2] && !int_hist[1];
        clr  = rd_en && !reg_sel && m_cfg[2];
        m_flag = fell || (m_flag && !clr);
        if (wr_en && reg_sel) m_cfg = {1'b0, wdata[6:0]};
        else if (wr_en && m_cfg[2]) m_data = wdata;
        else if (wr_en) m_dir = wdata;
        pin_hist.push_front(pin_in); void'(pin_hist.pop_back());
        int_hist.push_front(int_line); void'(int_hist.pop_back());
      end
      m_r2 = m_r1; m_r1 = 1;
    end
  end

  function automatic logic [7:0] model_rdata();
    if (reg_sel) return {m_flag, m_cfg[6:0]};
    if (m_cfg[2]) return (m_data & m_dir) | (pin_hist[1] & ~m_dir);
    return m_dir;
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (cmp_on) begin
    chk("R3 pin_oe",  pin_oe,  m_dir);
    chk("R3 pin_out", pin_out, m_data);
    chk("R4/R2/R5 rdata", rdata, model_rdata());
    chk("R8 irq", {7'b0, irq}, {7'b0, m_flag && m_cfg[0]});
    chk("R9 line", {7'b0, ctl_line_n}, {7'b0, m_cfg[3]});
  end

  task automatic drive(bit sel, bit wr, bit rd, logic [7:0] wd);
    @(negedge clk); #1;
    reg_sel = sel; wr_en = wr; rd_en = rd; wdata = wd;
  endtask
  task automatic idle(int n);
    for (int i = 0; i < n; i++) drive(0, 0, 0, 8'h00);
  endtask
  task automatic wr(bit sel, logic [7:0] wd);
    drive(sel, 1, 0, wd); idle(1);
  endtask
  task automatic rd_expect(string tag, bit sel, logic [7:0] exp);
    drive(sel, 0, 1, 8'h00);
    @(negedge clk); chk(tag, rdata, exp);
  endtask

  task automatic finish_sim();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_sim();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); cmp_on = 1'b1;
    #1 rst_n = 1'b1;
    idle(4);
    // R1 reset state
    rd_expect("R1 ctl reset", 1, 8'h08);
    rd_expect("R1 dir reset", 0, 8'h00);
    chk("R1 oe reset", pin_oe, 8'h00);
    chk("R1 line high", {7'b0, ctl_line_n}, 8'h01);
    // R2 direction access with bit2 clear
    wr(0, 8'hF0);
    rd_expect("R2 dir readback", 0, 8'hF0);
    chk("R3 oe follows dir", pin_oe, 8'hF0);
    // R5/R9 control store, bit3 low turns line low
    wr(1, 8'h34);
    rd_expect("R5 ctl readback", 1, 8'h34);
    chk("R9 line low", {7'b0, ctl_line_n}, 8'h00);
    // R4 mixed read
    wr(0, 8'hA5);
    pin_in = 8'h5A; idle(3);
    rd_expect("R4 mixed read", 0, 8'hAA);
    pin_in = 8'h03; idle(3);
    rd_expect("R4 mixed read 2", 0, 8'hA3);
    wr(1, 8'h30); wr(0, 8'h0F); wr(1, 8'h34);
    pin_in = 8'hC6; idle(3);
    rd_expect("R4 mask swap", 0, 8'hC5);
    // R6/R8 falling edge with enable
    wr(1, 8'h35);
    @(negedge clk); #1 int_line = 1'b0;
    idle(4);
    chk("R8 irq raised", {7'b0, irq}, 8'h01);
    // R7 direction read and control read keep flag
    wr(1, 8'h31);
    rd_expect("R7 dir read", 0, 8'h0F);
    rd_expect("R6 flag kept", 1, 8'hB1);
    wr(1, 8'h35);
    rd_expect("R7 clearing read", 0, 8'hC5);
    idle(1);
    chk("R7 irq cleared", {7'b0, irq}, 8'h00);
    // R10 rising edge ignored
    @(negedge clk); #1 int_line = 1'b1;
    idle(5);
    rd_expect("R10 no set", 1, 8'h35);
    // R7 simultaneous edge and clear keeps flag
    @(negedge clk); #1 int_line = 1'b0;
    drive(0, 0, 0, 8'h00);
    drive(0, 0, 1, 8'h00);
    idle(1);
    rd_expect("R7 set wins", 1, 8'hB5);
    // R8 gating with enable off
    wr(1, 8'h34);
    chk("R8 gated", {7'b0, irq}, 8'h00);
    wr(1, 8'h35);
    chk("R8 re-enabled", {7'b0, irq}, 8'h01);
    // R5 write to bit7 ignored after clearing
    rd_expect("R7 clear", 0, 8'hC5);
    wr(1, 8'hBC);
    rd_expect("R5 bit7 read-only", 1, 8'h3C);
    chk("R9 line high", {7'b0, ctl_line_n}, 8'h01);
    @(negedge clk); #1 int_line = 1'b1;
    idle(5);
    finish_sim();
  end
endmodule